// File: doc/BRIEF.md
# Audio Master-Clock Monitor and Mute Controller

This block supervises an audio serial port. A free-running counter in the master-clock domain counts rising edges of the asynchronous high-frequency master clock. The count is passed into the system-clock domain as Gray code through a two-stage synchronizer. A window timer in the system domain closes a measurement every `WIN_CYCLES` system cycles (32 by default). At each window close the block publishes the number of master-clock edges seen during that window. It then tests that number against programmable lower and upper limits. The first window after reset is discarded, because its starting point is not a real measurement.

An out-of-range result becomes one of four error sources. The other three come in from the serial port: underrun, overrun and framing/protocol error. Each source latches a sticky status bit, which software clears by writing a one. One enable mask chooses which sources may mute the audio, and a second mask chooses which may raise the interrupt. The mute output reacts in the same cycle as a raw enabled error or an external mute request, and it stays on while an enabled status bit remains set. Its active level is chosen by an input.

Top module: `aclk_guard`

## Requirements
- R1: `measCount` changes only at the close of a window of `WIN_CYCLES` system cycles, and then equals the number of master-clock rising edges in that window, within one edge.
- R2: After reset, `measValid` stays low and no clock-range error is raised until the second window has closed; the first window is ignored.
- R3: At each checked window close, status bit 3 is set when the count is below `minLimit` or above `maxLimit`; both limits are inclusive, so a count equal to a limit is in range.
- R4: Status bit 0 (underrun), bit 1 (overrun) and bit 2 (protocol error) are set on the clock edge after the matching input is high, and they stay set.
- R5: A one in `statusClear[i]` clears status bit i at the next edge; if the source of bit i is active in that same cycle, the bit stays set.
- R6: The mute output is asserted in the same cycle as any input error whose `muteMask` bit is one, and it stays asserted while a status bit with its `muteMask` bit set is one.
- R7: `muteReqIn` asserts the mute output at once, whatever the masks hold.
- R8: With `muteActiveHigh` = 1 the mute output is high when asserted; with 0 it is low when asserted and high when idle.
- R9: `irqOut` is high exactly when some status bit with its `irqMask` bit set is one. Bits that are masked off still latch in the status register but do not raise the interrupt.
- R10: While reset is held, status is 0, `irqOut` is 0, `measCount` is 0, `measValid` is 0 and the mute output is in its idle level.
- R11: An error whose `muteMask` bit is zero has no effect on the mute output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock |
| sysRstN | input | 1 | System-domain reset, active low, asynchronous |
| mclk | input | 1 | Master clock being measured |
| mclkRstN | input | 1 | Master-clock-domain reset, active low, asynchronous |
| minLimit | input | CNT_W | Lowest count accepted as in range |
| maxLimit | input | CNT_W | Highest count accepted as in range |
| underrunIn | input | 1 | Underrun error from the serial port |
| overrunIn | input | 1 | Overrun error from the serial port |
| protoErrIn | input | 1 | Protocol/framing error from the serial port |
| muteReqIn | input | 1 | External mute request, not masked |
| muteMask | input | 4 | Per-source enable for muting (bit order as in the status register) |
| irqMask | input | 4 | Per-source enable for the interrupt |
| muteActiveHigh | input | 1 | Mute polarity: 1 = high when muted, 0 = low when muted |
| statusClear | input | 4 | Write-one-to-clear strobe for the status bits |
| status | output | 4 | Sticky status: 0 underrun, 1 overrun, 2 protocol, 3 clock range |
| muteOut | output | 1 | Mute output |
| irqOut | output | 1 | Interrupt, level |
| measCount | output | CNT_W | Latest master-clock edge count per window |
| measValid | output | 1 | A valid measurement has been published |

## Verification
The mute output is combinational on the error inputs and `muteReqIn`, so the bench drives inputs on the falling edge and checks mute 1 ns later, in the same cycle. Status bits and the interrupt are registered once, so they are compared on the falling edge after the rising edge that sampled the input. A behavioural model makes this comparison on every clock. Clock-range results appear only at a window close, after about two synchronizer cycles of latency. For these, the bench waits at least two full windows after any change of limit, of period or of status, and only then reads `measCount` and status bit 3. The master-clock period is chosen so that a window holds a whole number of edges, which makes the boundary limits exact.

// File: rtl/aclk_guard_pkg.sv
package aclk_guard_pkg;

  // status bit positions; other logic decodes this order
  localparam int NUM_SRC   = 4;
  localparam int SRC_UNDER = 0;
  localparam int SRC_OVER  = 1;
  localparam int SRC_PROTO = 2;
  localparam int SRC_CLK   = 3;

  // strobes from the window control to the measurement datapath
  typedef struct packed {
    logic winEnd;    // last system cycle of a window
    logic rangeChk;  // window end that is not the first after reset
  } winStrobe_t;

endpackage

// File: rtl/aclk_guard_ctrl.sv
module aclk_guard_ctrl
  import aclk_guard_pkg::*;
#(
  parameter int WIN_CYCLES = 32
) (
  input  logic       sysClk,
  input  logic       sysRstN,
  output winStrobe_t strobe
);

  localparam int WIN_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [WIN_W-1:0] LAST_IDX = WIN_W'(WIN_CYCLES - 1);

  logic [WIN_W-1:0] winCnt;
  logic             firstDone;
  logic             lastCycle;

  assign lastCycle = (winCnt == LAST_IDX);

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      winCnt    <= '0;
      firstDone <= 1'b0;
    end else begin
      winCnt <= lastCycle ? '0 : winCnt + 1'b1;
      if (lastCycle) firstDone <= 1'b1;
    end
  end

  assign strobe.winEnd   = lastCycle;
  assign strobe.rangeChk = lastCycle & firstDone;

  // R1
  win_range_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    winCnt <= LAST_IDX);

  // R1
  win_single_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    strobe.winEnd |=> !strobe.winEnd);

endmodule

// File: rtl/aclk_guard_dp.sv
module aclk_guard_dp
  import aclk_guard_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             sysClk,
  input  logic             sysRstN,
  input  logic             mclk,
  input  logic             mclkRstN,
  input  winStrobe_t       strobe,
  input  logic [CNT_W-1:0] minLimit,
  input  logic [CNT_W-1:0] maxLimit,
  output logic [CNT_W-1:0] measCount,
  output logic             measValid,
  output logic             clkErr
);

  // master-clock domain: binary counter and its Gray image
  logic [CNT_W-1:0] mBin;
  logic [CNT_W-1:0] mGray;

  always_ff @(posedge mclk or negedge mclkRstN) begin
    if (!mclkRstN) begin
      mBin  <= '0;
      mGray <= '0;
    end else begin
      mBin  <= mBin + 1'b1;
      mGray <= (mBin + 1'b1) ^ ((mBin + 1'b1) >> 1);
    end
  end

  // R1
  gray_step_chk: assert property (@(posedge mclk) disable iff (!mclkRstN)
    $countones(mGray ^ $past(mGray)) <= 1);

  // system domain: two-stage synchronizer, decode, difference
  logic [CNT_W-1:0] syncA;
  logic [CNT_W-1:0] syncB;
  logic [CNT_W-1:0] syncBin;
  logic [CNT_W-1:0] prevBin;
  logic [CNT_W-1:0] delta;

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= mGray;
      syncB <= syncA;
    end
  end

  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      syncBin[i] = ^(syncB >> i);
    end
  end

  assign delta = syncBin - prevBin;

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      prevBin   <= '0;
      measCount <= '0;
      measValid <= 1'b0;
    end else begin
      if (strobe.winEnd) begin
        prevBin   <= syncBin;
        measCount <= delta;
      end
      if (strobe.rangeChk) measValid <= 1'b1;
    end
  end

  assign clkErr = strobe.rangeChk & ((delta < minLimit) | (delta > maxLimit));

  // R1
  meas_hold_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    !strobe.winEnd |=> $stable(measCount));

  // R2
  valid_rise_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    $rose(measValid) |-> $past(strobe.rangeChk));

  // R3
  clk_err_window_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    clkErr |-> strobe.winEnd);

endmodule

// File: rtl/aclk_guard_flags.sv
module aclk_guard_flags
  import aclk_guard_pkg::*;
(
  input  logic               sysClk,
  input  logic               sysRstN,
  input  logic [NUM_SRC-1:0] rawErr,
  input  logic [NUM_SRC-1:0] statusClear,
  input  logic [NUM_SRC-1:0] muteMask,
  input  logic [NUM_SRC-1:0] irqMask,
  input  logic               muteReqIn,
  input  logic               muteActiveHigh,
  output logic [NUM_SRC-1:0] status,
  output logic               muteOut,
  output logic               irqOut
);

  logic muteOn;

  // set has priority over a simultaneous clear
  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) status <= '0;
    else          status <= (status & ~statusClear) | rawErr;
  end

  assign muteOn  = muteReqIn | (|((rawErr | status) & muteMask));
  assign muteOut = muteActiveHigh ? muteOn : ~muteOn;
  assign irqOut  = |(status & irqMask);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_srcChk
    // R4
    set_sticky_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
      rawErr[g] |=> status[g]);

    // R5
    hold_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
      status[g] && !statusClear[g] |=> status[g]);

    // R5
    w1c_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
      status[g] && statusClear[g] && !rawErr[g] |=> !status[g]);
  end

  // R7
  req_mute_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    muteReqIn |-> (muteOut == muteActiveHigh));

endmodule

// File: rtl/aclk_guard.sv
module aclk_guard
  import aclk_guard_pkg::*;
#(
  parameter int WIN_CYCLES = 32,
  parameter int CNT_W      = 10
) (
  input  logic             sysClk,
  input  logic             sysRstN,
  input  logic             mclk,
  input  logic             mclkRstN,
  input  logic [CNT_W-1:0] minLimit,
  input  logic [CNT_W-1:0] maxLimit,
  input  logic             underrunIn,
  input  logic             overrunIn,
  input  logic             protoErrIn,
  input  logic             muteReqIn,
  input  logic [3:0]       muteMask,
  input  logic [3:0]       irqMask,
  input  logic             muteActiveHigh,
  input  logic [3:0]       statusClear,
  output logic [3:0]       status,
  output logic             muteOut,
  output logic             irqOut,
  output logic [CNT_W-1:0] measCount,
  output logic             measValid
);

  winStrobe_t         strobe;
  logic               clkErr;
  logic [NUM_SRC-1:0] rawErr;

  aclk_guard_ctrl #(.WIN_CYCLES(WIN_CYCLES)) u_ctrl (
    .sysClk (sysClk),
    .sysRstN(sysRstN),
    .strobe (strobe)
  );

  aclk_guard_dp #(.CNT_W(CNT_W)) u_dp (
    .sysClk   (sysClk),
    .sysRstN  (sysRstN),
    .mclk     (mclk),
    .mclkRstN (mclkRstN),
    .strobe   (strobe),
    .minLimit (minLimit),
    .maxLimit (maxLimit),
    .measCount(measCount),
    .measValid(measValid),
    .clkErr   (clkErr)
  );

  always_comb begin
    rawErr            = '0;
    rawErr[SRC_UNDER] = underrunIn;
    rawErr[SRC_OVER]  = overrunIn;
    rawErr[SRC_PROTO] = protoErrIn;
    rawErr[SRC_CLK]   = clkErr;
  end

  aclk_guard_flags u_flags (
    .sysClk        (sysClk),
    .sysRstN       (sysRstN),
    .rawErr        (rawErr),
    .statusClear   (statusClear),
    .muteMask      (muteMask),
    .irqMask       (irqMask),
    .muteReqIn     (muteReqIn),
    .muteActiveHigh(muteActiveHigh),
    .status        (status),
    .muteOut       (muteOut),
    .irqOut        (irqOut)
  );

endmodule

// File: tb/aclk_guard_bench.sv
`timescale 1ns/1ps
module aclk_guard_bench;

  localparam int CNT_W = 10;

  logic             sysClk = 1'b0;
  logic             sysRstN = 1'b0;
  logic             mclk = 1'b0;
  logic             mclkRstN;
  logic [CNT_W-1:0] minLimit;
  logic [CNT_W-1:0] maxLimit;
  logic             underrunIn, overrunIn, protoErrIn, muteReqIn;
  logic [3:0]       muteMask, irqMask, statusClear;
  logic             muteActiveHigh;
  logic [3:0]       status;
  logic             muteOut, irqOut, measValid;
  logic [CNT_W-1:0] measCount;

  int  checks = 0;
  int  errors = 0;
  bit  cmpOn = 1'b0;
  real mclkHalf = 4.0;

  assign mclkRstN = sysRstN;

  aclk_guard #(.WIN_CYCLES(32), .CNT_W(CNT_W)) u_aclk_guard (
    .sysClk(sysClk), .sysRstN(sysRstN), .mclk(mclk), .mclkRstN(mclkRstN),
    .minLimit(minLimit), .maxLimit(maxLimit),
    .underrunIn(underrunIn), .overrunIn(overrunIn), .protoErrIn(protoErrIn),
    .muteReqIn(muteReqIn), .muteMask(muteMask), .irqMask(irqMask),
    .muteActiveHigh(muteActiveHigh), .statusClear(statusClear),
    .status(status), .muteOut(muteOut), .irqOut(irqOut),
    .measCount(measCount), .measValid(measValid)
  );

  always #2 sysClk = ~sysClk;           // 250 MHz

  initial begin
    #1.3;
    forever #(mclkHalf) mclk = ~mclk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference for the three port-driven status bits
  logic [2:0] mdlStat = 3'b000;
  always @(posedge sysClk) begin
    if (!sysRstN) mdlStat = 3'b000;
    else mdlStat = (mdlStat & ~statusClear[2:0]) | {protoErrIn, overrunIn, underrunIn};
  end

  always @(negedge sysClk) begin
    #1;
    if (cmpOn) begin
      logic [3:0] expSt, rawV;
      logic       expMute, expPin, expIrq;
      expSt   = {status[3], mdlStat};
      rawV    = {1'b0, protoErrIn, overrunIn, underrunIn};
      expMute = muteReqIn | (|((rawV | expSt) & muteMask));
      expPin  = muteActiveHigh ? expMute : !expMute;
      expIrq  = |(expSt & irqMask);
      chk(status[2:0] == mdlStat, "R4 per-cycle status", int'(status[2:0]), int'(mdlStat));
      chk(muteOut == expPin, "R6 per-cycle mute", int'(muteOut), int'(expPin));
      chk(irqOut == expIrq, "R9 per-cycle irq", int'(irqOut), int'(expIrq));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge sysClk);
  endtask

  task automatic clearAll();
    @(negedge sysClk); statusClear = 4'hF;
    @(negedge sysClk); statusClear = 4'h0;
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    underrunIn = 0; overrunIn = 0; protoErrIn = 0; muteReqIn = 0;
    muteMask = 0; irqMask = 0; statusClear = 0; muteActiveHigh = 1;
    minLimit = 10'd100; maxLimit = 10'd100;

    cyc(5);
    #1;
    // R10 reset state
    chk(status == 0, "R10 status", int'(status), 0);
    chk(irqOut == 0, "R10 irq", int'(irqOut), 0);
    chk(measValid == 0, "R10 measValid", int'(measValid), 0);
    chk(measCount == 0, "R10 measCount", int'(measCount), 0);
    chk(muteOut == 0, "R10 mute idle", int'(muteOut), 0);
    @(negedge sysClk); sysRstN = 1;

    // R2: first window closed but ignored
    cyc(40); #1;
    chk(measValid == 0, "R2 valid after first window", int'(measValid), 0);
    chk(status[3] == 0, "R2 no range error on first window", int'(status[3]), 0);
    cyc(30); #1;
    chk(measValid == 1, "R2 valid after second window", int'(measValid), 1);
    chk(status[3] == 1, "R3 count 16 outside [100,100]", int'(status[3]), 1);

    // R1 measurement: 8 ns master clock, 128 ns window -> 16
    minLimit = 0; maxLimit = '1;
    clearAll(); cyc(40); #1;
    chk(measCount >= 15 && measCount <= 17, "R1 count at 8 ns", int'(measCount), 16);

    // R3 inclusive boundary
    minLimit = 16; maxLimit = 16;
    clearAll(); cyc(70); #1;
    chk(status[3] == 0, "R3 count equal to both limits", int'(status[3]), 0);
    minLimit = 17;
    clearAll(); cyc(70); #1;
    chk(status[3] == 1, "R3 count below min", int'(status[3]), 1);
    muteMask = 4'b1000; irqMask = 4'b1000; #1;
    chk(muteOut == 1, "R6 mute held by clock status", int'(muteOut), 1);
    chk(irqOut == 1, "R9 irq from clock status", int'(irqOut), 1);
    muteMask = 0; irqMask = 0;
    minLimit = 0; maxLimit = 15;
    clearAll(); cyc(70); #1;
    chk(status[3] == 1, "R3 count above max", int'(status[3]), 1);

    // R1 at a faster master clock: 5 ns -> 25.6 per window
    maxLimit = '1;
    mclkHalf = 2.5;
    cyc(70); clearAll(); cyc(70); #1;
    chk(measCount >= 24 && measCount <= 27, "R1 count at 5 ns", int'(measCount), 26);
    chk(status[3] == 0, "R3 wide limits no error", int'(status[3]), 0);

    // port-driven errors with per-cycle model active
    muteMask = 4'b0111; irqMask = 4'b0111;
    clearAll();
    cmpOn = 1;
    @(negedge sysClk); underrunIn = 1; #1;
    chk(muteOut == 1, "R6 immediate mute on underrun", int'(muteOut), 1);
    @(negedge sysClk); underrunIn = 0; #1;
    chk(status[0] == 1, "R4 underrun latched", int'(status[0]), 1);
    chk(irqOut == 1, "R9 irq on underrun", int'(irqOut), 1);
    cyc(3); #1;
    chk(status[0] == 1, "R4 underrun sticky", int'(status[0]), 1);
    @(negedge sysClk); statusClear = 4'b0001;
    @(negedge sysClk); statusClear = 0; #1;
    chk(status[0] == 0, "R5 write-one clear", int'(status[0]), 0);

    @(negedge sysClk); overrunIn = 1; statusClear = 4'b0010;
    @(negedge sysClk); overrunIn = 0; statusClear = 0; #1;
    chk(status[1] == 1, "R5 set wins over clear", int'(status[1]), 1);
    clearAll();

    muteMask = 0; irqMask = 0;
    @(negedge sysClk); protoErrIn = 1; #1;
    chk(muteOut == 0, "R11 masked error no mute", int'(muteOut), 0);
    @(negedge sysClk); protoErrIn = 0; #1;
    chk(status[2] == 1, "R4 masked error still latched", int'(status[2]), 1);
    chk(irqOut == 0, "R9 masked bit no irq", int'(irqOut), 0);
    chk(muteOut == 0, "R11 masked status no mute", int'(muteOut), 0);
    clearAll();

    @(negedge sysClk); muteReqIn = 1; #1;
    chk(muteOut == 1, "R7 request with masks clear", int'(muteOut), 1);
    @(negedge sysClk); muteActiveHigh = 0; #1;
    chk(muteOut == 0, "R8 active-low muted level", int'(muteOut), 0);
    @(negedge sysClk); muteReqIn = 0; #1;
    chk(muteOut == 1, "R8 active-low idle level", int'(muteOut), 1);
    @(negedge sysClk); muteActiveHigh = 1;
    cyc(3);
    cmpOn = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule